// File: doc/BRIEF.md
# Bidirectional Slotted Ring Stop

This block is one stop on a slotted ring that links on-chip agents such as processor cores, cache slices, a graphics engine and a system agent. The ring runs in two directions at once. Every clock, each direction moves one slot to the next stop. A slot carries a valid bit, a destination stop number, a source stop number and a 32-byte payload. The stop forwards slots that belong to other stops. It hands slots addressed to itself to the local agent. It places the agent's own messages into empty slots, on whichever direction reaches the target in fewer hops.

Arbitration is distributed. Each stop tells its downstream neighbour one cycle ahead whether the slot it will send next is empty, and injection uses only slots flagged empty in this way. Traffic already on the ring always wins, so nothing on the ring is dropped or overwritten. The same stop logic is instantiated once for each independent ring (data, request, acknowledge, snoop), with that ring's payload width. A full ring is built by chaining stops: the clockwise output of stop k feeds stop k+1 modulo the ring size, and the counter-clockwise output of stop k feeds stop k-1.

Top module: `ring_stop`

## Requirements
- R1: While reset is held low, both ring outputs show empty slots, both next-free outputs are 1, `ej_valid` is 0 and `inj_ready` is 1.
- R2: A local message goes clockwise (toward stop ID+1) when the clockwise hop count (dst-ID mod N) is no greater than the counter-clockwise count (ID-dst mod N). A tie therefore goes clockwise. Otherwise the message goes counter-clockwise.
- R3: On an idle ring, a message accepted at a clock edge raises `ej_valid` at its destination right after the h-th following edge, where h is the shorter hop count. A message addressed to its own stop makes a full clockwise circle, so h is N.
- R4: A valid incoming slot whose destination is another stop appears on the same direction's output one clock later, with destination, source and payload unchanged.
- R5: An incoming slot addressed to this stop is shown on `ej_src`/`ej_data` with `ej_valid` high. If it is accepted with `ej_ready`, the slot leaves this stop empty on the next clock.
- R6: A slot addressed to this stop that is not accepted is forwarded unchanged in its direction, and it comes back after a full circle.
- R7: When slots addressed to this stop arrive in both directions in the same cycle, only one is offered. Priority starts with clockwise and switches direction after each such conflict that the agent accepts. The losing slot continues around the ring.
- R8: A buffered message enters a direction's output only if that direction's input next-free flag was 1 at the previous clock edge. Passing traffic keeps priority, so the buffered message waits.
- R9: Each next-free output equals the inverse of the same direction's output valid one clock later.
- R10: Each direction has a one-entry injection buffer. `inj_ready` is 0 while the buffer for the direction chosen for `inj_dst` is full, and this does not depend on the state of the other direction's buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_in_vld | input | 1 | Clockwise incoming slot valid |
| cw_in_dst | input | ID_W | Clockwise incoming destination stop |
| cw_in_src | input | ID_W | Clockwise incoming source stop |
| cw_in_data | input | PAYLOAD_W | Clockwise incoming payload |
| cw_in_next_free | input | 1 | Upstream says next clockwise slot is empty |
| ccw_in_vld | input | 1 | Counter-clockwise incoming slot valid |
| ccw_in_dst | input | ID_W | Counter-clockwise incoming destination stop |
| ccw_in_src | input | ID_W | Counter-clockwise incoming source stop |
| ccw_in_data | input | PAYLOAD_W | Counter-clockwise incoming payload |
| ccw_in_next_free | input | 1 | Upstream says next counter-clockwise slot is empty |
| cw_out_vld | output | 1 | Clockwise outgoing slot valid |
| cw_out_dst | output | ID_W | Clockwise outgoing destination stop |
| cw_out_src | output | ID_W | Clockwise outgoing source stop |
| cw_out_data | output | PAYLOAD_W | Clockwise outgoing payload |
| cw_out_next_free | output | 1 | Next clockwise outgoing slot will be empty |
| ccw_out_vld | output | 1 | Counter-clockwise outgoing slot valid |
| ccw_out_dst | output | ID_W | Counter-clockwise outgoing destination stop |
| ccw_out_src | output | ID_W | Counter-clockwise outgoing source stop |
| ccw_out_data | output | PAYLOAD_W | Counter-clockwise outgoing payload |
| ccw_out_next_free | output | 1 | Next counter-clockwise outgoing slot will be empty |
| inj_valid | input | 1 | Local agent offers a message |
| inj_ready | output | 1 | Buffer for the chosen direction can take it |
| inj_dst | input | ID_W | Destination stop of the local message |
| inj_data | input | PAYLOAD_W | Payload of the local message |
| ej_valid | output | 1 | A slot for this stop is offered |
| ej_ready | input | 1 | Local agent accepts the offered slot |
| ej_src | output | ID_W | Source stop of the offered slot |
| ej_data | output | PAYLOAD_W | Payload of the offered slot |

## Verification
The bench connects six stops into a ring and sends single messages between source and destination pairs. The pairs are chosen to cover a short clockwise path, a short counter-clockwise path, paths that wrap past stop 0, exact halfway ties and a message addressed to its own stop. Watching which output carries the message one clock after injection shows the direction that was chosen, and counting edges until ejection separates the shorter path from the longer one. Directed cases cover the following: a message refused by the agent and forwarded around the ring; two messages reaching the same stop from opposite directions in two rounds, to show that priority switches; and an injection that meets passing traffic, to show the wait and the per-direction backpressure.

// File: rtl/ring_stop_pkg.sv
package ring_stop_pkg;
  typedef enum logic {
    DIR_CW  = 1'b0,
    DIR_CCW = 1'b1
  } ring_dir_e;

  localparam int NUM_DIRS = 2;
endpackage

// File: rtl/ring_hop_sel.sv
module ring_hop_sel
  import ring_stop_pkg::*;
#(
  parameter int N_STOPS = 8,
  parameter int STOP_ID = 0,
  parameter int ID_W    = 3
) (
  input  logic [ID_W-1:0] dst,
  output ring_dir_e       dir
);
  int dst_i;
  int hops_cw;
  int hops_ccw;

  // Hop counts in each direction; ties and self-addressed go clockwise.
  always_comb begin
    dst_i    = int'(dst);
    hops_cw  = (dst_i >= STOP_ID) ? (dst_i - STOP_ID) : (dst_i + N_STOPS - STOP_ID);
    hops_ccw = (STOP_ID >= dst_i) ? (STOP_ID - dst_i) : (STOP_ID + N_STOPS - dst_i);
    dir      = (hops_cw <= hops_ccw) ? DIR_CW : DIR_CCW;
  end
endmodule

// File: rtl/ring_inj_buf.sv
module ring_inj_buf #(
  parameter int BODY_W = 262
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drain,
  input  logic [BODY_W-1:0] load_body,
  output logic              full,
  output logic [BODY_W-1:0] body
);
  logic              full_q;
  logic              full_d;
  logic [BODY_W-1:0] body_q;

  always_comb begin
    full_d = (full_q & ~drain) | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load) body_q <= load_body;
  end

  assign full = full_q;
  assign body = body_q;
endmodule

// File: rtl/ring_lane.sv
module ring_lane #(
  parameter int BODY_W = 262
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [BODY_W-1:0] in_body,
  input  logic              in_next_free,
  input  logic              take,
  input  logic              buf_full,
  input  logic [BODY_W-1:0] buf_body,
  output logic              drain,
  output logic              out_vld,
  output logic [BODY_W-1:0] out_body,
  output logic              out_next_free
);
  logic              free_q;
  logic              vld_q;
  logic [BODY_W-1:0] body_q;
  logic              pass;
  logic              nxt_vld;
  logic [BODY_W-1:0] nxt_body;

  always_comb begin
    pass     = in_vld & ~take;
    drain    = buf_full & free_q;
    nxt_vld  = pass | drain;
    nxt_body = pass ? in_body : buf_body;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      free_q <= in_next_free;
      vld_q  <= nxt_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (nxt_vld) body_q <= nxt_body;
  end

  assign out_vld       = vld_q;
  assign out_body      = body_q;
  assign out_next_free = ~nxt_vld;
endmodule

// File: rtl/ring_eject_arb.sv
module ring_eject_arb
  import ring_stop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hit,
  input  logic       ready,
  output logic [1:0] grant,
  output logic [1:0] take
);
  ring_dir_e prio_q;
  ring_dir_e prio_d;
  logic      both;

  always_comb begin
    both     = hit[0] & hit[1];
    grant[0] = hit[0] & (~hit[1] | (prio_q == DIR_CW));
    grant[1] = hit[1] & (~hit[0] | (prio_q == DIR_CCW));
    take     = grant & {2{ready}};
    prio_d   = prio_q;
    if (both && ready) prio_d = (prio_q == DIR_CW) ? DIR_CCW : DIR_CW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= DIR_CW;
    else        prio_q <= prio_d;
  end
endmodule

// File: rtl/ring_stop.sv
module ring_stop
  import ring_stop_pkg::*;
#(
  parameter  int N_STOPS   = 8,
  parameter  int STOP_ID   = 0,
  parameter  int PAYLOAD_W = 256,
  localparam int ID_W      = (N_STOPS > 1) ? $clog2(N_STOPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cw_in_vld,
  input  logic [ID_W-1:0]      cw_in_dst,
  input  logic [ID_W-1:0]      cw_in_src,
  input  logic [PAYLOAD_W-1:0] cw_in_data,
  input  logic                 cw_in_next_free,
  input  logic                 ccw_in_vld,
  input  logic [ID_W-1:0]      ccw_in_dst,
  input  logic [ID_W-1:0]      ccw_in_src,
  input  logic [PAYLOAD_W-1:0] ccw_in_data,
  input  logic                 ccw_in_next_free,
  output logic                 cw_out_vld,
  output logic [ID_W-1:0]      cw_out_dst,
  output logic [ID_W-1:0]      cw_out_src,
  output logic [PAYLOAD_W-1:0] cw_out_data,
  output logic                 cw_out_next_free,
  output logic                 ccw_out_vld,
  output logic [ID_W-1:0]      ccw_out_dst,
  output logic [ID_W-1:0]      ccw_out_src,
  output logic [PAYLOAD_W-1:0] ccw_out_data,
  output logic                 ccw_out_next_free,
  input  logic                 inj_valid,
  output logic                 inj_ready,
  input  logic [ID_W-1:0]      inj_dst,
  input  logic [PAYLOAD_W-1:0] inj_data,
  output logic                 ej_valid,
  input  logic                 ej_ready,
  output logic [ID_W-1:0]      ej_src,
  output logic [PAYLOAD_W-1:0] ej_data
);
  // Slot body layout: {dst, src, payload}
  localparam int BODY_W            = 2 * ID_W + PAYLOAD_W;
  localparam int DATA_HI           = PAYLOAD_W - 1;
  localparam int SRC_LO            = PAYLOAD_W;
  localparam int DST_LO            = PAYLOAD_W + ID_W;
  localparam logic [ID_W-1:0] MY_ID = ID_W'(STOP_ID);

  logic              in_vld       [NUM_DIRS];
  logic [BODY_W-1:0] in_body      [NUM_DIRS];
  logic              in_next_free [NUM_DIRS];
  logic              out_vld      [NUM_DIRS];
  logic [BODY_W-1:0] out_body     [NUM_DIRS];
  logic              out_nfree    [NUM_DIRS];
  logic              buf_full     [NUM_DIRS];
  logic [BODY_W-1:0] buf_body     [NUM_DIRS];
  logic              buf_load     [NUM_DIRS];
  logic              buf_drain    [NUM_DIRS];
  logic [1:0]        hit;
  logic [1:0]        grant;
  logic [1:0]        take;
  ring_dir_e         inj_dir;
  logic [BODY_W-1:0] inj_body;

  assign in_vld[0]       = cw_in_vld;
  assign in_body[0]      = {cw_in_dst, cw_in_src, cw_in_data};
  assign in_next_free[0] = cw_in_next_free;
  assign in_vld[1]       = ccw_in_vld;
  assign in_body[1]      = {ccw_in_dst, ccw_in_src, ccw_in_data};
  assign in_next_free[1] = ccw_in_next_free;

  ring_hop_sel #(
    .N_STOPS (N_STOPS),
    .STOP_ID (STOP_ID),
    .ID_W    (ID_W)
  ) u_hop_sel (
    .dst (inj_dst),
    .dir (inj_dir)
  );

  assign inj_body  = {inj_dst, MY_ID, inj_data};
  assign inj_ready = ~buf_full[inj_dir];

  ring_eject_arb u_eject_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .ready (ej_ready),
    .grant (grant),
    .take  (take)
  );

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    assign hit[d]      = in_vld[d] & (in_body[d][DST_LO +: ID_W] == MY_ID);
    assign buf_load[d] = inj_valid & ~buf_full[d] & (inj_dir == ring_dir_e'(d));

    ring_inj_buf #(
      .BODY_W (BODY_W)
    ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (buf_load[d]),
      .drain     (buf_drain[d]),
      .load_body (inj_body),
      .full      (buf_full[d]),
      .body      (buf_body[d])
    );

    ring_lane #(
      .BODY_W (BODY_W)
    ) u_lane (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_vld        (in_vld[d]),
      .in_body       (in_body[d]),
      .in_next_free  (in_next_free[d]),
      .take          (take[d]),
      .buf_full      (buf_full[d]),
      .buf_body      (buf_body[d]),
      .drain         (buf_drain[d]),
      .out_vld       (out_vld[d]),
      .out_body      (out_body[d]),
      .out_next_free (out_nfree[d])
    );
  end

  always_comb begin
    ej_valid = |hit;
    ej_src   = grant[1] ? in_body[1][SRC_LO +: ID_W] : in_body[0][SRC_LO +: ID_W];
    ej_data  = grant[1] ? in_body[1][DATA_HI:0]      : in_body[0][DATA_HI:0];
  end

  assign cw_out_vld        = out_vld[0];
  assign cw_out_dst        = out_body[0][DST_LO +: ID_W];
  assign cw_out_src        = out_body[0][SRC_LO +: ID_W];
  assign cw_out_data       = out_body[0][DATA_HI:0];
  assign cw_out_next_free  = out_nfree[0];
  assign ccw_out_vld       = out_vld[1];
  assign ccw_out_dst       = out_body[1][DST_LO +: ID_W];
  assign ccw_out_src       = out_body[1][SRC_LO +: ID_W];
  assign ccw_out_data      = out_body[1][DATA_HI:0];
  assign ccw_out_next_free = out_nfree[1];
endmodule

// File: rtl/ring_stop_chk.sv
module ring_stop_chk #(
  parameter  int N_STOPS   = 8,
  parameter  int STOP_ID   = 0,
  parameter  int PAYLOAD_W = 256,
  localparam int ID_W      = (N_STOPS > 1) ? $clog2(N_STOPS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cw_in_vld,
  input logic [ID_W-1:0]      cw_in_dst,
  input logic [ID_W-1:0]      cw_in_src,
  input logic [PAYLOAD_W-1:0] cw_in_data,
  input logic                 cw_in_next_free,
  input logic                 ccw_in_vld,
  input logic [ID_W-1:0]      ccw_in_dst,
  input logic [ID_W-1:0]      ccw_in_src,
  input logic [PAYLOAD_W-1:0] ccw_in_data,
  input logic                 ccw_in_next_free,
  input logic                 cw_out_vld,
  input logic [ID_W-1:0]      cw_out_dst,
  input logic [ID_W-1:0]      cw_out_src,
  input logic [PAYLOAD_W-1:0] cw_out_data,
  input logic                 cw_out_next_free,
  input logic                 ccw_out_vld,
  input logic [ID_W-1:0]      ccw_out_dst,
  input logic [ID_W-1:0]      ccw_out_src,
  input logic [PAYLOAD_W-1:0] ccw_out_data,
  input logic                 ccw_out_next_free,
  input logic                 inj_valid,
  input logic                 inj_ready,
  input logic [ID_W-1:0]      inj_dst,
  input logic [PAYLOAD_W-1:0] inj_data,
  input logic                 ej_valid,
  input logic                 ej_ready,
  input logic [ID_W-1:0]      ej_src,
  input logic [PAYLOAD_W-1:0] ej_data
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(STOP_ID);

  logic cw_hit;
  logic ccw_hit;
  assign cw_hit  = cw_in_vld && (cw_in_dst == MY_ID);
  assign ccw_hit = ccw_in_vld && (ccw_in_dst == MY_ID);

  a_r9_cw_flag_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cw_out_vld == !$past(cw_out_next_free)));

  a_r9_ccw_flag_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ccw_out_vld == !$past(ccw_out_next_free)));

  a_r4_cw_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_in_vld && cw_in_dst != MY_ID) |=>
      (cw_out_vld && cw_out_dst == $past(cw_in_dst) && cw_out_src == $past(cw_in_src)
       && cw_out_data == $past(cw_in_data)));

  a_r4_ccw_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ccw_in_vld && ccw_in_dst != MY_ID) |=>
      (ccw_out_vld && ccw_out_dst == $past(ccw_in_dst) && ccw_out_src == $past(ccw_in_src)
       && ccw_out_data == $past(ccw_in_data)));

  a_r6_cw_refused_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_hit && !ej_ready) |=> (cw_out_vld && cw_out_src == $past(cw_in_src)));

  a_r5_cw_taken_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_hit && !ccw_hit && ej_ready) |=> !cw_out_vld);

  a_r8_cw_flag_honest: assert property (@(posedge clk) disable iff (!rst_n)
    cw_in_next_free |=> !cw_in_vld);

  a_r8_ccw_flag_honest: assert property (@(posedge clk) disable iff (!rst_n)
    ccw_in_next_free |=> !ccw_in_vld);
endmodule

bind ring_stop ring_stop_chk #(
  .N_STOPS   (N_STOPS),
  .STOP_ID   (STOP_ID),
  .PAYLOAD_W (PAYLOAD_W)
) u_chk (.*);

// File: tb/ring_stop_tb.sv
module ring_stop_tb;
  localparam int NS = 6;
  localparam int PW = 256;
  localparam int IW = 3;
  localparam int NV = 10;

  // Each vector: {src, dst, expected dir (0 cw / 1 ccw), expected hops}
  localparam logic [15:0] VEC [NV] = '{
    {4'd0, 4'd1, 4'd0, 4'd1},
    {4'd0, 4'd3, 4'd0, 4'd3},
    {4'd0, 4'd4, 4'd1, 4'd2},
    {4'd2, 4'd1, 4'd1, 4'd1},
    {4'd5, 4'd0, 4'd0, 4'd1},
    {4'd1, 4'd5, 4'd1, 4'd2},
    {4'd3, 4'd0, 4'd0, 4'd3},
    {4'd4, 4'd4, 4'd0, 4'd6},
    {4'd2, 4'd5, 4'd0, 4'd3},
    {4'd5, 4'd3, 4'd1, 4'd2}
  };

  logic clk;
  logic rst_n;

  logic          cw_ov [NS];
  logic [IW-1:0] cw_od [NS];
  logic [IW-1:0] cw_os [NS];
  logic [PW-1:0] cw_odata [NS];
  logic          cw_of [NS];
  logic          ccw_ov [NS];
  logic [IW-1:0] ccw_od [NS];
  logic [IW-1:0] ccw_os [NS];
  logic [PW-1:0] ccw_odata [NS];
  logic          ccw_of [NS];
  logic          inj_valid [NS];
  logic          inj_ready [NS];
  logic [IW-1:0] inj_dst [NS];
  logic [PW-1:0] inj_data [NS];
  logic          ej_valid [NS];
  logic          ej_ready [NS];
  logic [IW-1:0] ej_src [NS];
  logic [PW-1:0] ej_data [NS];

  int checks;
  int errors;
  int mon_checks;
  int mon_errors;
  bit mon_en;
  int cycles;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  for (genvar k = 0; k < NS; k++) begin : g_stop
    localparam int UP = (k + NS - 1) % NS;
    localparam int DN = (k + 1) % NS;
    ring_stop #(
      .N_STOPS   (NS),
      .STOP_ID   (k),
      .PAYLOAD_W (PW)
    ) u_dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .cw_in_vld         (cw_ov[UP]),
      .cw_in_dst         (cw_od[UP]),
      .cw_in_src         (cw_os[UP]),
      .cw_in_data        (cw_odata[UP]),
      .cw_in_next_free   (cw_of[UP]),
      .ccw_in_vld        (ccw_ov[DN]),
      .ccw_in_dst        (ccw_od[DN]),
      .ccw_in_src        (ccw_os[DN]),
      .ccw_in_data       (ccw_odata[DN]),
      .ccw_in_next_free  (ccw_of[DN]),
      .cw_out_vld        (cw_ov[k]),
      .cw_out_dst        (cw_od[k]),
      .cw_out_src        (cw_os[k]),
      .cw_out_data       (cw_odata[k]),
      .cw_out_next_free  (cw_of[k]),
      .ccw_out_vld       (ccw_ov[k]),
      .ccw_out_dst       (ccw_od[k]),
      .ccw_out_src       (ccw_os[k]),
      .ccw_out_data      (ccw_odata[k]),
      .ccw_out_next_free (ccw_of[k]),
      .inj_valid         (inj_valid[k]),
      .inj_ready         (inj_ready[k]),
      .inj_dst           (inj_dst[k]),
      .inj_data          (inj_data[k]),
      .ej_valid          (ej_valid[k]),
      .ej_ready          (ej_ready[k]),
      .ej_src            (ej_src[k]),
      .ej_data           (ej_data[k])
    );
  end

  function automatic logic [PW-1:0] mk_data(input int s, input int d, input int tag);
    return {8{8'(s), 8'(d), 16'(tag)}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ej(input int d, input int s, input int lim, output int edges);
    edges = -1;
    for (int e = 1; e <= lim; e++) begin
      tick();
      if (ej_valid[d] && ej_src[d] == IW'(s)) begin
        edges = e;
        break;
      end
    end
  endtask

  // R9: next-free flag predicts the output valid one clock later
  logic prev_cwf [NS];
  logic prev_ccwf [NS];
  always @(negedge clk) begin
    if (mon_en) begin
      for (int k = 0; k < NS; k++) begin
        mon_checks += 2;
        if (prev_cwf[k] == cw_ov[k]) begin
          mon_errors++;
          $display("FAIL R9 stop %0d cw actual=%0b expected=%0b", k, cw_ov[k], !prev_cwf[k]);
        end
        if (prev_ccwf[k] == ccw_ov[k]) begin
          mon_errors++;
          $display("FAIL R9 stop %0d ccw actual=%0b expected=%0b", k, ccw_ov[k], !prev_ccwf[k]);
        end
      end
    end
    for (int k = 0; k < NS; k++) begin
      prev_cwf[k]  = cw_of[k];
      prev_ccwf[k] = ccw_of[k];
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int got;
    int s;
    int d;
    int dir;
    int hops;
    int mid;
    checks = 0;
    errors = 0;
    mon_checks = 0;
    mon_errors = 0;
    mon_en = 1'b0;
    rst_n = 1'b0;
    for (int k = 0; k < NS; k++) begin
      inj_valid[k] = 1'b0;
      inj_dst[k]   = '0;
      inj_data[k]  = '0;
      ej_ready[k]  = 1'b1;
    end
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int k = 0; k < NS; k++) begin
      chk(!cw_ov[k] && !ccw_ov[k], "R1 outputs empty", {cw_ov[k], ccw_ov[k]}, 0);
      chk(cw_of[k] && ccw_of[k], "R1 next-free high", {cw_of[k], ccw_of[k]}, 3);
      chk(!ej_valid[k] && inj_ready[k], "R1 eject idle / ready", {ej_valid[k], inj_ready[k]}, 1);
    end
    rst_n = 1'b1;
    tick();
    mon_en = 1'b1;

    // R2 R3 R4 R5: vector walk
    for (int v = 0; v < NV; v++) begin
      s    = int'(VEC[v][15:12]);
      d    = int'(VEC[v][11:8]);
      dir  = int'(VEC[v][7:4]);
      hops = int'(VEC[v][3:0]);
      #1;
      inj_valid[s] = 1'b1;
      inj_dst[s]   = IW'(d);
      inj_data[s]  = mk_data(s, d, v);
      #1;
      chk(inj_ready[s], "R10 ready on idle", inj_ready[s], 1);
      @(posedge clk);
      @(negedge clk);
      #1 inj_valid[s] = 1'b0;
      got = -1;
      for (int e = 1; e <= NS + 2; e++) begin
        tick();
        if (e == 1) begin
          if (dir == 0)
            chk(cw_ov[s] && cw_os[s] == IW'(s) && !ccw_ov[s], "R2 went clockwise", cw_ov[s], 1);
          else
            chk(ccw_ov[s] && ccw_os[s] == IW'(s) && !cw_ov[s], "R2 went counter-clockwise", ccw_ov[s], 1);
        end
        if (e == 2 && hops >= 2) begin
          mid = (dir == 0) ? (s + 1) % NS : (s + NS - 1) % NS;
          if (dir == 0)
            chk(cw_ov[mid] && cw_odata[mid] == mk_data(s, d, v), "R4 passed on", cw_ov[mid], 1);
          else
            chk(ccw_ov[mid] && ccw_odata[mid] == mk_data(s, d, v), "R4 passed on", ccw_ov[mid], 1);
        end
        if (ej_valid[d] && ej_src[d] == IW'(s)) begin
          got = e;
          break;
        end
      end
      chk(got == hops, "R3 hop latency", 64'(got), 64'(hops));
      chk(ej_data[d] == mk_data(s, d, v), "R5 ejected payload", ej_data[d][31:0], mk_data(s, d, v)[31:0]);
      tick();
      if (dir == 0) chk(!cw_ov[d], "R5 slot emptied", cw_ov[d], 0);
      else          chk(!ccw_ov[d], "R5 slot emptied", ccw_ov[d], 0);
      repeat (2) tick();
    end

    // R6: refused slot keeps circulating
    ej_ready[2] = 1'b0;
    inj_valid[0] = 1'b1;
    inj_dst[0]   = IW'(2);
    inj_data[0]  = mk_data(0, 2, 100);
    @(posedge clk);
    @(negedge clk);
    #1 inj_valid[0] = 1'b0;
    repeat (2) tick();
    chk(ej_valid[2] && ej_src[2] == IW'(0), "R6 offered while refused", ej_valid[2], 1);
    tick();
    chk(cw_ov[2] && cw_os[2] == IW'(0) && cw_odata[2] == mk_data(0, 2, 100), "R6 forwarded", cw_ov[2], 1);
    #1 ej_ready[2] = 1'b1;
    wait_ej(2, 0, NS + 2, got);
    chk(got == NS - 1, "R6 back after full circle", 64'(got), 64'(NS - 1));
    repeat (3) tick();

    // R7: both directions arrive together, priority switches
    for (int round = 0; round < 2; round++) begin
      #1;
      inj_valid[1] = 1'b1; inj_dst[1] = IW'(3); inj_data[1] = mk_data(1, 3, 200 + round);
      inj_valid[5] = 1'b1; inj_dst[5] = IW'(3); inj_data[5] = mk_data(5, 3, 300 + round);
      @(posedge clk);
      @(negedge clk);
      #1 inj_valid[1] = 1'b0;
      inj_valid[5] = 1'b0;
      repeat (2) tick();
      chk(ej_valid[3] && ej_src[3] == IW'(round == 0 ? 1 : 5), "R7 winner of conflict",
          ej_src[3], (round == 0) ? 1 : 5);
      wait_ej(3, (round == 0) ? 5 : 1, NS + 2, got);
      chk(got == NS, "R7 loser returns after circle", 64'(got), 64'(NS));
      repeat (3) tick();
    end

    // R8 R10: injection meets passing traffic
    #1;
    inj_valid[5] = 1'b1; inj_dst[5] = IW'(1); inj_data[5] = mk_data(5, 1, 400);
    @(posedge clk);
    @(negedge clk);
    #1;
    inj_valid[5] = 1'b0;
    inj_valid[0] = 1'b1; inj_dst[0] = IW'(2); inj_data[0] = mk_data(0, 2, 401);
    @(posedge clk);
    @(negedge clk);
    #1 inj_valid[0] = 1'b0;
    #1;
    chk(!inj_ready[0], "R10 cw buffer full", inj_ready[0], 0);
    inj_dst[0] = IW'(4);
    #1;
    chk(inj_ready[0], "R10 ccw buffer independent", inj_ready[0], 1);
    inj_dst[0] = IW'(2);
    tick();
    chk(cw_ov[0] && cw_os[0] == IW'(5), "R8 passing traffic first", cw_os[0], 5);
    tick();
    chk(cw_ov[0] && cw_os[0] == IW'(0) && cw_od[0] == IW'(2), "R8 injected into freed slot", cw_os[0], 0);
    chk(inj_ready[0], "R10 ready after drain", inj_ready[0], 1);
    repeat (6) tick();

    finish_run();
  end
endmodule